// File: doc/BRIEF.md
# Decoder Start-Up Sequencer

This block governs how a paging decoder core comes out of reset. While the reset request is high, every status, alert and bus-drive output is held at a safe level. The core clock enable is held off, and the decoder stays OFF whatever the enable input does. Once reset is released, the block walks an address counter across a small configuration store, one word per clock. It keeps the captured words hidden, so every programmed setting reads as zero until the last word is in.

When loading completes, the block raises a one-cycle interrupt pulse, enables the serial bus drivers and exposes the settings. It then puts the decoder ON or OFF according to the enable input. The receiver enables follow ON status. If the loaded configuration selects a frequency synthesizer, the receiver enables are held back until the synthesizer latch strobe has risen twice after loading. A later drop of the enable input turns the decoder OFF on the next clock.

Top module: `dbs_boot_ctrl`

## Requirements
- R1: While `boot_rst` is high, `is_on_o`, `rx_en_o`, `rx_osc_en_o`, `int_o`, `ser_oe_o`, all four alert outputs, `irq_mask_o` (0 means every interrupt is enabled) and `settings_o` are 0, whatever `en_in` does. Raising `boot_rst` clears them at once, without waiting for a clock edge.
- R2: `core_clk_en_o` is low while `boot_rst` is high. It rises on the second rising clock edge after `boot_rst` falls.
- R3: `cfg_addr_o` is 0 while the clock enable is off. It then presents addresses 0,1,…,7 on consecutive cycles, starting in the cycle after `core_clk_en_o` rises. `cfg_data_i` is a combinational read of the presented address and is captured on the following edge. After the last word, the address rests at 0.
- R4: Until loading completes, `settings_o`, `irq_mask_o` and `ser_oe_o` read 0. Completion occurs on the eighth edge after `core_clk_en_o` rises. From that edge on, word i appears at `settings_o[i*8 +: 8]` and `ser_oe_o` is 1.
- R5: `int_o` is high for exactly one cycle, on the completion edge, and stays low until the next reset.
- R6: From the completion edge on, `is_on_o` equals `en_in` as sampled at the previous rising edge. Before that edge it is 0.
- R7: When bit 0 of word 0 (synthesizer select) is 0, `rx_en_o` and `rx_osc_en_o` equal `is_on_o`.
- R8: When bit 0 of word 0 is 1, `rx_en_o` and `rx_osc_en_o` stay 0 until `synth_strobe_i` has shown two rising edges sampled after completion. A strobe held high for several cycles counts once, and strobes during loading do not count. The receiver enables rise on the edge that samples the second rising edge, provided `is_on_o` is 1.
- R9: If `en_in` is low at a rising edge after completion, `is_on_o` and both receiver enables are 0 after that edge. When `en_in` returns high, they come back on the next edge without a new strobe count.
- R10: `led_o`, `vib_o`, `tone_hi_o` and `tone_lo_oe_o` equal `alert_req_i & is_on_o` gated by the alert select field, bits 2:0 of word 1. Bit 0 gates `led_o`, bit 1 gates `vib_o`, and bit 2 gates both tone outputs. Bits 7:4 of word 1 appear on `irq_mask_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| boot_rst | input | 1 | Reset request, active high, asynchronous assert |
| en_in | input | 1 | Decoder enable (ON when high) |
| cfg_addr_o | output | 3 | Configuration store read address |
| cfg_data_i | input | 8 | Configuration store read data (combinational) |
| synth_strobe_i | input | 1 | Synthesizer latch strobe |
| alert_req_i | input | 1 | Alert request from the decoder core |
| core_clk_en_o | output | 1 | Core clock enable |
| settings_o | output | 64 | Loaded configuration words, zero until load completes |
| is_on_o | output | 1 | ON status |
| rx_en_o | output | 1 | Receiver enable |
| rx_osc_en_o | output | 1 | Receiver oscillator enable |
| int_o | output | 1 | Start-up complete pulse |
| irq_mask_o | output | 4 | Interrupt mask field (1 = masked) |
| led_o | output | 1 | LED alert drive |
| vib_o | output | 1 | Vibrator alert drive |
| tone_hi_o | output | 1 | Tone transducer high-side drive |
| tone_lo_oe_o | output | 1 | Tone transducer low-side output enable |
| ser_oe_o | output | 1 | Serial bus pin drive enable |

## Verification
Two collisions are forced in the same cycle. In the first, `en_in` drops on exactly the edge where loading completes. The bench expects the settings, `int_o` and `ser_oe_o` to appear while `is_on_o` stays 0. In the second, the second synthesizer strobe arrives in the same cycle that `en_in` falls. The bench expects the strobe count to be kept while the receivers stay off, and then expects them to turn on with the next high `en_in` without any further strobe. A scoreboard model built from the requirements predicts every output after each edge.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [0:0] {
    PH_LOAD = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  localparam int CFG_SYNTH_WORD = 0;
  localparam int CFG_SYNTH_BIT  = 0;
  localparam int CFG_ALERT_WORD = 1;
  localparam int ALERT_N        = 3;
  localparam int MASK_LSB       = 4;
  localparam int MASK_W         = 4;

endpackage

// File: rtl/dbs_rst_sync.sv
module dbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_req,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge rst_req) begin
    if (rst_req) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

  a_r2_release_in_order: assert property (@(posedge clk) disable iff (rst_req)
    rst_n_o |-> chain_q[0]);

endmodule

// File: rtl/dbs_cfg_loader.sv
module dbs_cfg_loader #(
  parameter int WORDS = 8,
  parameter int W     = 8,
  localparam int AW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [W-1:0]     rd_data_i,
  output logic [WORDS*W-1:0] shadow_o,
  output logic             last_o,
  output logic             done_o
);

  logic [AW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic          last;

  always_comb begin
    last   = !done_q && (cnt_q == AW'(WORDS-1));
    done_d = done_q | last;
    if (done_q) begin
      cnt_d = cnt_q;
    end else if (last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
    logic [W-1:0] word_q;
    logic         cap_en;
    assign cap_en = !done_q && (cnt_q == AW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (cap_en) begin
        word_q <= rd_data_i;
      end
    end
    assign shadow_o[gi*W +: W] = word_q;
  end

  assign rd_addr_o = cnt_q;
  assign last_o    = last;
  assign done_o    = done_q;

  a_r3_addr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_q && !last) |=> (rd_addr_o == $past(rd_addr_o) + 1'b1));

  a_r3_addr_rests: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (rd_addr_o == '0));

  a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);

endmodule

// File: rtl/dbs_status_fsm.sv
module dbs_status_fsm
  import dbs_pkg::*;
#(
  parameter int PULSES = 2,
  localparam int PW    = $clog2(PULSES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_last_i,
  input  logic en_in,
  input  logic synth_en_i,
  input  logic strobe_i,
  output logic is_on_o,
  output logic rx_en_o,
  output logic int_o
);

  phase_e        phase_q, phase_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic          strobe_q;
  logic          on_q, on_d;
  logic          rx_q, rx_d;
  logic          int_q, int_d;
  logic          strobe_rise;

  always_comb begin
    phase_d     = phase_q;
    cnt_d       = cnt_q;
    strobe_rise = strobe_i && !strobe_q;
    if (phase_q == PH_LOAD && load_last_i) begin
      phase_d = PH_RUN;
    end
    if (phase_q == PH_RUN && strobe_rise && cnt_q != PW'(PULSES)) begin
      cnt_d = cnt_q + 1'b1;
    end
    on_d  = (phase_d == PH_RUN) && en_in;
    rx_d  = on_d && (!synth_en_i || cnt_d == PW'(PULSES));
    int_d = (phase_q == PH_LOAD) && load_last_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_LOAD;
      cnt_q    <= '0;
      strobe_q <= 1'b0;
      on_q     <= 1'b0;
      rx_q     <= 1'b0;
      int_q    <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      strobe_q <= strobe_i;
      on_q     <= on_d;
      rx_q     <= rx_d;
      int_q    <= int_d;
    end
  end

  assign is_on_o = on_q;
  assign rx_en_o = rx_q;
  assign int_o   = int_q;

  a_r1_off_while_loading: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOAD) |-> (!is_on_o && !rx_en_o));

  a_r9_on_tracks_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN) |=> (is_on_o == $past(en_in)));

  a_r8_rx_waits_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_o && synth_en_i) |-> (cnt_q == PW'(PULSES)));

  a_r7_rx_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en_o |-> is_on_o);

  a_r5_int_single: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |=> !int_o);

endmodule

// File: rtl/dbs_boot_ctrl.sv
module dbs_boot_ctrl
  import dbs_pkg::*;
#(
  parameter int CFG_WORDS   = 8,
  parameter int CFG_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SYN_PULSES  = 2
) (
  input  logic                       clk,
  input  logic                       boot_rst,
  input  logic                       en_in,
  output logic [$clog2(CFG_WORDS)-1:0] cfg_addr_o,
  input  logic [CFG_W-1:0]           cfg_data_i,
  input  logic                       synth_strobe_i,
  input  logic                       alert_req_i,
  output logic                       core_clk_en_o,
  output logic [CFG_WORDS*CFG_W-1:0] settings_o,
  output logic                       is_on_o,
  output logic                       rx_en_o,
  output logic                       rx_osc_en_o,
  output logic                       int_o,
  output logic [MASK_W-1:0]          irq_mask_o,
  output logic                       led_o,
  output logic                       vib_o,
  output logic                       tone_hi_o,
  output logic                       tone_lo_oe_o,
  output logic                       ser_oe_o
);

  localparam int ALERT_BASE = CFG_ALERT_WORD * CFG_W;

  logic                       rst_n;
  logic [CFG_WORDS*CFG_W-1:0] shadow;
  logic                       load_last;
  logic                       load_done;
  logic                       synth_en;
  logic                       on_s;
  logic [ALERT_N-1:0]         alert_sel;
  logic [ALERT_N-1:0]         alert_drv;

  dbs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_req (boot_rst),
    .rst_n_o (rst_n)
  );

  dbs_cfg_loader #(.WORDS(CFG_WORDS), .W(CFG_W)) u_loader (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_o (cfg_addr_o),
    .rd_data_i (cfg_data_i),
    .shadow_o  (shadow),
    .last_o    (load_last),
    .done_o    (load_done)
  );

  assign synth_en = shadow[CFG_SYNTH_WORD*CFG_W + CFG_SYNTH_BIT];

  dbs_status_fsm #(.PULSES(SYN_PULSES)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_last_i (load_last),
    .en_in       (en_in),
    .synth_en_i  (synth_en),
    .strobe_i    (synth_strobe_i),
    .is_on_o     (on_s),
    .rx_en_o     (rx_en_o),
    .int_o       (int_o)
  );

  always_comb begin
    settings_o = load_done ? shadow : '0;
    alert_sel  = settings_o[ALERT_BASE +: ALERT_N];
    irq_mask_o = settings_o[ALERT_BASE + MASK_LSB +: MASK_W];
  end

  for (genvar ai = 0; ai < ALERT_N; ai++) begin : g_alert
    assign alert_drv[ai] = alert_req_i && on_s && alert_sel[ai];
  end

  assign core_clk_en_o = rst_n;
  assign is_on_o       = on_s;
  assign rx_osc_en_o   = rx_en_o;
  assign led_o         = alert_drv[0];
  assign vib_o         = alert_drv[1];
  assign tone_hi_o     = alert_drv[2];
  assign tone_lo_oe_o  = alert_drv[2];
  assign ser_oe_o      = load_done;

  a_r1_reset_quiet: assert property (@(posedge clk)
    boot_rst |-> (!core_clk_en_o && !is_on_o && !ser_oe_o && settings_o == '0));

  a_r4_settings_with_int: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_oe_o) |-> int_o);

  a_r10_alert_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
    (led_o || vib_o || tone_hi_o || tone_lo_oe_o) |-> is_on_o);

endmodule

// File: tb/dbs_boot_ctrl_tb.sv
module dbs_boot_ctrl_tb_top;

  typedef struct {
    string       req;
    logic [16:0] obs;
    logic [63:0] set;
  } exp_t;

  logic        clk = 1'b0;
  logic        boot_rst = 1'b1;
  logic        en_in = 1'b0;
  logic [2:0]  cfg_addr_o;
  logic [7:0]  cfg_data_i;
  logic        synth_strobe_i = 1'b0;
  logic        alert_req_i = 1'b0;
  logic        core_clk_en_o;
  logic [63:0] settings_o;
  logic        is_on_o, rx_en_o, rx_osc_en_o, int_o;
  logic [3:0]  irq_mask_o;
  logic        led_o, vib_o, tone_hi_o, tone_lo_oe_o, ser_oe_o;

  int errors = 0;
  int checks = 0;
  exp_t q[$];
  logic done_all = 1'b0;

  // scenario memory content
  logic       m_synth;
  logic [2:0] m_sel;
  logic [3:0] m_mask;
  // scoreboard model state
  int   m_cyc;
  logic m_done, m_prev;
  int   m_pul;

  always #2 clk = ~clk;

  dbs_boot_ctrl dut_i (
    .clk(clk), .boot_rst(boot_rst), .en_in(en_in), .cfg_addr_o(cfg_addr_o),
    .cfg_data_i(cfg_data_i), .synth_strobe_i(synth_strobe_i), .alert_req_i(alert_req_i),
    .core_clk_en_o(core_clk_en_o), .settings_o(settings_o), .is_on_o(is_on_o),
    .rx_en_o(rx_en_o), .rx_osc_en_o(rx_osc_en_o), .int_o(int_o), .irq_mask_o(irq_mask_o),
    .led_o(led_o), .vib_o(vib_o), .tone_hi_o(tone_hi_o), .tone_lo_oe_o(tone_lo_oe_o),
    .ser_oe_o(ser_oe_o)
  );

  function automatic logic [7:0] mem_word(input logic [2:0] a);
    if (a == 3'd0) return {7'h2B, m_synth};
    if (a == 3'd1) return {m_mask, 1'b0, m_sel};
    return 8'h05 + 8'({5'd0, a}) * 8'h1D;
  endfunction

  function automatic logic [63:0] mem_vec();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = mem_word(3'(i));
    return v;
  endfunction

  always_comb cfg_data_i = mem_word(cfg_addr_o);

  function automatic logic [16:0] pack_obs(input logic [2:0] addr, input logic ce, on, rx,
                                           input logic irq, ser, input logic [2:0] al,
                                           input logic [3:0] mask);
    return {addr, ce, on, rx, rx, irq, ser, al[0], al[1], al[2], al[2], mask};
  endfunction

  function automatic logic [16:0] dut_obs();
    return {cfg_addr_o, core_clk_en_o, is_on_o, rx_en_o, rx_osc_en_o, int_o, ser_oe_o,
            led_o, vib_o, tone_hi_o, tone_lo_oe_o, irq_mask_o};
  endfunction

  // driver: drives one cycle of stimulus and pushes the expected outcome
  task automatic step(input logic rst, en, stb, areq, input string req);
    exp_t it;
    logic done_prev, rise, on, rx, ce, irq;
    logic [2:0] addr;
    @(negedge clk);
    boot_rst = rst; en_in = en; synth_strobe_i = stb; alert_req_i = areq;
    if (rst) begin
      m_cyc = 0; m_done = 1'b0; m_prev = 1'b0; m_pul = 0;
      it.obs = '0; it.set = '0;
    end else begin
      m_cyc = m_cyc + 1;
      done_prev = m_done;
      irq = (m_cyc == 10);
      if (m_cyc == 10) m_done = 1'b1;
      rise = stb && !m_prev;
      if (m_cyc >= 3) m_prev = stb;
      if (done_prev && rise && m_pul < 2) m_pul = m_pul + 1;
      ce   = (m_cyc >= 2);
      on   = m_done && en;
      rx   = on && (!m_synth || m_pul == 2);
      addr = (m_cyc >= 2 && m_cyc <= 9) ? 3'(m_cyc - 2) : 3'd0;
      it.obs = pack_obs(addr, ce, on, rx, irq, m_done,
                        (on && areq) ? m_sel : 3'b000, m_done ? m_mask : 4'h0);
      it.set = m_done ? mem_vec() : 64'h0;
    end
    it.req = req;
    q.push_back(it);
  endtask

  // monitor: compares after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t it;
        it = q.pop_front();
        checks++;
        if (dut_obs() !== it.obs || settings_o !== it.set) begin
          errors++;
          $display("FAIL %s: obs=%h set=%h expected obs=%h set=%h",
                   it.req, dut_obs(), settings_o, it.obs, it.set);
        end
      end
    end
  end

  task automatic async_check(input string req);
    @(negedge clk);
    boot_rst = 1'b1; en_in = 1'b1;
    #1;
    checks++;
    if (core_clk_en_o !== 1'b0 || is_on_o !== 1'b0 || rx_en_o !== 1'b0 ||
        settings_o !== 64'h0 || ser_oe_o !== 1'b0 || irq_mask_o !== 4'h0) begin
      errors++;
      $display("FAIL %s: async clear clk_en=%b on=%b rx=%b ser=%b set=%h expected all 0",
               req, core_clk_en_o, is_on_o, rx_en_o, ser_oe_o, settings_o);
    end
  endtask

  task automatic boot(input logic en_done, input logic stb_during_load);
    step(1, 1, 0, 1, "R1");
    step(1, 1, 1, 1, "R1");
    step(1, 1, 0, 1, "R1");
    for (int i = 1; i <= 9; i++) begin
      step(0, 1, stb_during_load && (i == 4 || i == 6), 1,
           (i <= 2) ? "R2" : ((i % 2 == 0) ? "R3" : "R4"));
    end
    step(0, en_done, 0, 1, "R6");
  endtask

  initial begin
    m_synth = 1'b0; m_sel = 3'b101; m_mask = 4'b1010;
    m_cyc = 0; m_done = 1'b0; m_prev = 1'b0; m_pul = 0;
    // A: no synthesizer, enable high at completion
    boot(1'b1, 1'b0);
    step(0, 1, 0, 1, "R5");
    step(0, 1, 0, 1, "R7");
    step(0, 0, 0, 1, "R9");
    step(0, 1, 0, 1, "R9");
    step(0, 1, 0, 0, "R10");
    step(0, 1, 0, 1, "R10");
    async_check("R1");
    // B: synthesizer on, enable low at completion, strobes during load ignored
    m_synth = 1'b1; m_sel = 3'b010; m_mask = 4'b0101;
    boot(1'b0, 1'b1);
    step(0, 0, 0, 1, "R6");
    step(0, 1, 0, 1, "R8");
    step(0, 1, 1, 1, "R8");
    step(0, 1, 1, 1, "R8");
    step(0, 1, 0, 1, "R8");
    step(0, 0, 1, 1, "R9");
    step(0, 1, 0, 1, "R9");
    step(0, 1, 1, 1, "R8");
    step(0, 1, 0, 0, "R10");
    // C: synthesizer on, enable falls exactly at completion
    m_synth = 1'b1; m_sel = 3'b111; m_mask = 4'b1111;
    boot(1'b0, 1'b0);
    step(0, 1, 1, 1, "R8");
    step(0, 1, 0, 1, "R8");
    step(0, 1, 1, 1, "R8");
    step(0, 1, 0, 1, "R10");
    step(0, 1, 0, 1, "R5");
    @(negedge clk);
    @(negedge clk);
    done_all = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_all) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule